// File: doc/BRIEF.md
# 8-bit Timer with Compare-Driven Waveform Output

An 8-bit timer/counter advanced by a prescaled copy of the system clock. It has one compare value and drives one waveform pin. A two-bit waveform-mode input picks the counting scheme: free-running, clear-on-compare, single-slope PWM or dual-slope PWM. A two-bit output-action input decides what the pin does on a compare hit and at the counter boundaries. A combinational enable flag says when the waveform pin takes over from ordinary port use.

The counter keeps its count direction in an enumerated two-state machine. In **ST_UP** (`DIR_UP`) the count rises. The transition **UP→DOWN** is taken only in dual-slope mode, on an advance from 255. In **ST_DOWN** (`DIR_DOWN`) the count falls. The transition **DOWN→UP** is taken on an advance from 0. Any mode other than dual-slope forces **ST_UP**. Registered one-cycle strobes report compare hits and overflow.

Top module: `tmr8_pwm_top`

## Requirements
- R1: While `rst_i` is high, `count_o`, `wave_o`, `match_o` and `ovf_o` are all 0, the compare buffer is 0 and the direction state is ST_UP.
- R2: `wave_en_o` is 0 when `out_mode_i` is 00 in every waveform mode, and also when `out_mode_i` is 01 in either PWM mode (`wave_mode_i` 01 or 11). It is 1 otherwise. While `wave_en_o` is 0, `wave_o` holds its value.
- R3: In the non-PWM modes (`wave_mode_i` 00 free-running, 10 clear-on-compare), a compare hit makes `wave_o` toggle for `out_mode_i`=01, go to 0 for 10 and go to 1 for 11.
- R4: In free-running mode the counter wraps from 255 to 0. In clear-on-compare mode (10), an advance taken while the count equals `cmp_i` loads 0 instead of incrementing.
- R5: In single-slope PWM (`wave_mode_i`=11) the count runs 0..255 and wraps. The advance from 255 sets `wave_o` for `out_mode_i`=10 and clears it for 11. A compare hit clears it for 10 and sets it for 11. In steady state, mode 10 is high for cmp+1 of every 256 counts.
- R6: In single-slope PWM with a compare value of 255, the boundary action overrides the compare hit: mode 10 stays high and mode 11 stays low.
- R7: In dual-slope PWM (`wave_mode_i`=01) the count goes 0..255..0, a period of 510 advances. The direction changes only at 255 and at 0.
- R8: In dual-slope PWM the action on a compare hit uses the direction of the next step. Mode 10 clears `wave_o` when the next step is up and sets it when the next step is down; mode 11 does the reverse. A compare value of 0 gives a constant low and 255 a constant high for mode 10. In steady state, mode 10 is high for 2×cmp of every 510 counts.
- R9: In both PWM modes the compare value is buffered. `cmp_i` is copied into the buffer only on the advance from 255. In the non-PWM modes `cmp_i` acts at once.
- R10: `clk_sel_i` 000, 110 and 111 halt the counter. Codes 001..101 advance it every 1, 8, 64, 256 or 1024 system clocks, on the cycles where the low bits of a free-running prescale counter (cleared by reset) are all ones.
- R11: `match_o` pulses for one cycle after an advance taken while the count equals the effective compare value. `ovf_o` pulses after the advance from 255 in the free-running, clear-on-compare and single-slope modes, and after the advance from 0 in ST_DOWN in dual-slope mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wave_mode_i | input | 2 | Counting scheme: 00 free-running, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM |
| out_mode_i | input | 2 | Pin action selection |
| clk_sel_i | input | 3 | Prescaler / halt selection |
| cmp_i | input | 8 | Compare value |
| wave_o | output | 1 | Waveform pin value |
| wave_en_o | output | 1 | Waveform overrides port use |
| count_o | output | 8 | Counter value |
| match_o | output | 1 | Compare-hit strobe |
| ovf_o | output | 1 | Overflow / bottom strobe |

## Verification
`count_o`, `wave_o`, `match_o` and `ovf_o` are registered and change on the same clock edge that takes an advance, so each is due one edge after the cycle where the prescaler fires. `wave_en_o` is combinational from the mode inputs and is valid in the same cycle. A cycle model in the bench pushes one expected item per edge into a scoreboard queue. A monitor pops it 1 ns after that edge, well away from the negative-edge stimulus changes. Duty-cycle windows are counted only after the first full period, because the start-up period differs from steady state.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_PHASE  = 2'b01,
        WM_CTC    = 2'b10,
        WM_FAST   = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF  = 2'b00,
        OM_ALT  = 2'b01,
        OM_LOW  = 2'b10,
        OM_HIGH = 2'b11
    } out_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr8_prescale.sv
`timescale 1ns/1ps
module tmr8_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) pre_q <= '0;
        else       pre_q <= pre_q + 1'b1;
    end

    // divide ratios 1, 8, 64, 256, 1024 for codes 1..5; other codes halt
    always_comb begin
        unique case (sel_i)
            3'd1:    tick_o = 1'b1;
            3'd2:    tick_o = &pre_q[2:0];
            3'd3:    tick_o = &pre_q[5:0];
            3'd4:    tick_o = &pre_q[7:0];
            3'd5:    tick_o = &pre_q[9:0];
            default: tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr8_count.sv
`timescale 1ns/1ps
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       mode_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_now_o,
    output logic             next_down_o,
    output logic             match_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wave_mode_e       mode;
    dir_e             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, buf_q, cmp_eff;
    logic             pwm, ovf_d, match_q, ovf_q;

    assign mode    = wave_mode_e'(mode_i);
    assign pwm     = (mode == WM_PHASE) || (mode == WM_FAST);
    assign cmp_eff = pwm ? buf_q : cmp_i;
    assign hit_now_o   = tick_i && (cnt_q == cmp_eff);
    assign next_down_o = (dir_q == DIR_UP) ? ((mode == WM_PHASE) && (cnt_q == TOP))
                                           : (cnt_q != '0);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dir_q   <= DIR_UP;
            cnt_q   <= '0;
            buf_q   <= '0;
            match_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            dir_q   <= dir_d;
            cnt_q   <= cnt_d;
            match_q <= hit_now_o;
            ovf_q   <= ovf_d;
            if (!pwm || (tick_i && cnt_q == TOP)) buf_q <= cmp_i;
        end
    end

    // next-state logic
    always_comb begin
        cnt_d = cnt_q;
        dir_d = (mode == WM_PHASE) ? dir_q : DIR_UP;
        ovf_d = 1'b0;
        if (tick_i) begin
            unique case (mode)
                WM_NORMAL, WM_FAST: begin
                    ovf_d = (cnt_q == TOP);
                    cnt_d = cnt_q + ONE;
                end
                WM_CTC: begin
                    ovf_d = (cnt_q == TOP);
                    cnt_d = (cnt_q == cmp_i) ? '0 : cnt_q + ONE;
                end
                WM_PHASE: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (cnt_q == TOP) begin
                                dir_d = DIR_DOWN;
                                cnt_d = cnt_q - ONE;
                            end else begin
                                cnt_d = cnt_q + ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == '0) begin
                                dir_d = DIR_UP;
                                cnt_d = ONE;
                                ovf_d = 1'b1;
                            end else begin
                                cnt_d = cnt_q - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = match_q;
    assign ovf_o   = ovf_q;

    p_ctc_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == WM_CTC && tick_i && cnt_q == cmp_i) |=> (cnt_q == '0));
    p_phase_turn_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == WM_PHASE && tick_i && cnt_q == TOP) |=> (dir_q == DIR_DOWN && cnt_q == TOP - ONE));
    p_buf_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm && !(tick_i && cnt_q == TOP)) |=> $stable(buf_q));
    p_ovf_single_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_q |=> !ovf_q);
endmodule

// File: rtl/tmr8_wavegen.sv
`timescale 1ns/1ps
module tmr8_wavegen
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       omode_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             hit_i,
    input  logic             next_down_i,
    output logic             wave_o,
    output logic             en_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    wave_mode_e mode;
    out_mode_e  om;
    logic       pwm, wave_q, wave_d;

    assign mode = wave_mode_e'(mode_i);
    assign om   = out_mode_e'(omode_i);
    assign pwm  = (mode == WM_PHASE) || (mode == WM_FAST);
    assign en_o = (om != OM_OFF) && !(pwm && om == OM_ALT);

    always_ff @(posedge clk_i) begin
        if (rst_i) wave_q <= 1'b0;
        else       wave_q <= wave_d;
    end

    always_comb begin
        wave_d = wave_q;
        unique case (mode)
            WM_NORMAL, WM_CTC: begin
                if (hit_i) begin
                    unique case (om)
                        OM_OFF:  wave_d = wave_q;
                        OM_ALT:  wave_d = ~wave_q;
                        OM_LOW:  wave_d = 1'b0;
                        OM_HIGH: wave_d = 1'b1;
                    endcase
                end
            end
            WM_FAST: begin
                if (tick_i && cnt_i == TOP) begin
                    if (om == OM_LOW)       wave_d = 1'b1;
                    else if (om == OM_HIGH) wave_d = 1'b0;
                end else if (hit_i) begin
                    if (om == OM_LOW)       wave_d = 1'b0;
                    else if (om == OM_HIGH) wave_d = 1'b1;
                end
            end
            WM_PHASE: begin
                if (hit_i) begin
                    if (om == OM_LOW)       wave_d = next_down_i;
                    else if (om == OM_HIGH) wave_d = !next_down_i;
                end
            end
        endcase
    end

    assign wave_o = wave_q;

    p_off_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_o |=> $stable(wave_q));
    p_toggle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode == WM_NORMAL || mode == WM_CTC) && om == OM_ALT && hit_i) |=> (wave_q != $past(wave_q)));
    p_fast_bottom_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == WM_FAST && om == OM_HIGH && tick_i && cnt_i == TOP) |=> !wave_q);
endmodule

// File: rtl/tmr8_pwm_top.sv
`timescale 1ns/1ps
module tmr8_pwm_top #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       wave_mode_i,
    input  logic [1:0]       out_mode_i,
    input  logic [2:0]       clk_sel_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             wave_o,
    output logic             wave_en_o,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o,
    output logic             ovf_o
);
    logic tick, hit_now, next_down;

    tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i(clk_i), .rst_i(rst_i), .sel_i(clk_sel_i), .tick_o(tick)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .mode_i(wave_mode_i), .tick_i(tick),
        .cmp_i(cmp_i), .cnt_o(count_o), .hit_now_o(hit_now),
        .next_down_o(next_down), .match_o(match_o), .ovf_o(ovf_o)
    );

    tmr8_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk_i(clk_i), .rst_i(rst_i), .mode_i(wave_mode_i), .omode_i(out_mode_i),
        .tick_i(tick), .cnt_i(count_o), .hit_i(hit_now),
        .next_down_i(next_down), .wave_o(wave_o), .en_o(wave_en_o)
    );

    p_stop_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (clk_sel_i == 3'd0 || clk_sel_i == 3'd6 || clk_sel_i == 3'd7) |=> $stable(count_o));
endmodule

// File: tb/tmr8_pwm_top_tb_top.sv
`timescale 1ns/1ps
module tmr8_pwm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] wm = 2'd0, om = 2'd0;
    logic [2:0] cs = 3'd1;
    logic [7:0] cmp = 8'd0;
    logic       wave, wave_en, match, ovf;
    logic [7:0] count;

    always #2.5 clk = ~clk;

    tmr8_pwm_top dut_i (
        .clk_i(clk), .rst_i(rst), .wave_mode_i(wm), .out_mode_i(om),
        .clk_sel_i(cs), .cmp_i(cmp), .wave_o(wave), .wave_en_o(wave_en),
        .count_o(count), .match_o(match), .ovf_o(ovf)
    );

    typedef struct {
        int cnt;
        bit wave;
        bit match;
        bit ovf;
    } exp_t;
    exp_t  sb_q[$];
    string scen = "R1";
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference model, one item per edge
    int m_pre = 0, m_cnt = 0, m_buf = 0;
    bit m_down = 0, m_wave = 0;
    always @(posedge clk) begin : model
        bit tk, pwm, mt, ov, gd;
        int eff;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_buf = 0; m_down = 0; m_wave = 0;
            sb_q.push_back('{cnt: 0, wave: 0, match: 0, ovf: 0});
        end else begin
            case (cs)
                3'd1: tk = 1;
                3'd2: tk = (m_pre % 8) == 7;
                3'd3: tk = (m_pre % 64) == 63;
                3'd4: tk = (m_pre % 256) == 255;
                3'd5: tk = (m_pre % 1024) == 1023;
                default: tk = 0;
            endcase
            m_pre = (m_pre + 1) % 1024;
            pwm = (wm == 2'd1) || (wm == 2'd3);
            eff = pwm ? m_buf : int'(cmp);
            mt  = tk && (m_cnt == eff);
            ov  = 0;
            gd  = m_down ? (m_cnt != 0) : ((wm == 2'd1) && m_cnt == 255);
            if (tk) begin
                if (wm == 2'd0 || wm == 2'd2) begin
                    if (mt) begin
                        if (om == 2'd1) m_wave = !m_wave;
                        else if (om == 2'd2) m_wave = 0;
                        else if (om == 2'd3) m_wave = 1;
                    end
                end else if (wm == 2'd3) begin
                    if (m_cnt == 255) begin
                        if (om == 2'd2) m_wave = 1; else if (om == 2'd3) m_wave = 0;
                    end else if (mt) begin
                        if (om == 2'd2) m_wave = 0; else if (om == 2'd3) m_wave = 1;
                    end
                end else begin
                    if (mt) begin
                        if (om == 2'd2) m_wave = gd; else if (om == 2'd3) m_wave = !gd;
                    end
                end
            end
            if (!pwm || (tk && m_cnt == 255)) m_buf = int'(cmp);
            if (wm != 2'd1) m_down = 0;
            if (tk) begin
                if (wm == 2'd1) begin
                    if (!m_down) begin
                        if (m_cnt == 255) begin m_down = 1; m_cnt = 254; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin m_down = 0; m_cnt = 1; ov = 1; end
                        else m_cnt = m_cnt - 1;
                    end
                end else begin
                    ov = (m_cnt == 255);
                    if (wm == 2'd2 && m_cnt == int'(cmp)) m_cnt = 0;
                    else m_cnt = (m_cnt + 1) % 256;
                end
            end
            sb_q.push_back('{cnt: m_cnt, wave: m_wave, match: mt, ovf: ov});
        end
    end

    // monitor: compares 1 ns after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                bit   en_exp;
                e = sb_q.pop_front();
                en_exp = (om != 2'd0) && !((wm == 2'd1 || wm == 2'd3) && om == 2'd1);
                chk(int'(count) == e.cnt, scen, "count", int'(count), e.cnt);
                chk(wave == e.wave, scen, "wave", int'(wave), int'(e.wave));
                chk(match == e.match, "R11", "match", int'(match), int'(e.match));
                chk(ovf == e.ovf, "R11", "ovf", int'(ovf), int'(e.ovf));
                chk(wave_en == en_exp, "R2", "wave_en", int'(wave_en), int'(en_exp));
            end
        end
    end

    task automatic run(input logic [1:0] w, input logic [1:0] o, input logic [2:0] c,
                       input logic [7:0] v, input int n, input string tag);
        @(negedge clk);
        rst = 1'b1; wm = w; om = o; cs = c; cmp = v; scen = tag;
        @(negedge clk);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic duty(input int win, input int exp, input string tag);
        int hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (wave) hi++;
        end
        chk(hi == exp, tag, "duty high count", hi, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held in reset
        chk(count == 8'd0, "R1", "count in reset", int'(count), 0);
        chk(wave == 1'b0, "R1", "wave in reset", int'(wave), 0);
        chk(match == 1'b0 && ovf == 1'b0, "R1", "strobes in reset", int'(match) + int'(ovf), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        run(2'd0, 2'd1, 3'd1, 8'd100, 600, "R3");
        run(2'd0, 2'd2, 3'd1, 8'd50, 300, "R3");
        run(2'd0, 2'd3, 3'd1, 8'd50, 300, "R3");
        run(2'd2, 2'd1, 3'd1, 8'd20, 200, "R4");
        run(2'd2, 2'd3, 3'd1, 8'd255, 600, "R4");
        run(2'd0, 2'd0, 3'd1, 8'd10, 300, "R2");
        run(2'd3, 2'd1, 3'd1, 8'd10, 300, "R2");
        run(2'd1, 2'd1, 3'd1, 8'd10, 600, "R2");

        run(2'd3, 2'd2, 3'd1, 8'd0, 600, "R5");
        run(2'd3, 2'd2, 3'd1, 8'd100, 600, "R5");
        duty(256, 101, "R5");
        run(2'd3, 2'd3, 3'd1, 8'd100, 600, "R5");
        duty(256, 155, "R5");
        run(2'd3, 2'd2, 3'd1, 8'd255, 600, "R6");
        duty(256, 256, "R6");
        run(2'd3, 2'd3, 3'd1, 8'd255, 600, "R6");
        duty(256, 0, "R6");

        run(2'd1, 2'd2, 3'd1, 8'd100, 1100, "R7");
        duty(510, 200, "R8");
        run(2'd1, 2'd3, 3'd1, 8'd100, 1100, "R8");
        duty(510, 310, "R8");
        run(2'd1, 2'd2, 3'd1, 8'd0, 1100, "R8");
        duty(510, 0, "R8");
        run(2'd1, 2'd2, 3'd1, 8'd255, 1100, "R8");
        duty(510, 510, "R8");

        // R9: compare change mid-period in both PWM modes
        run(2'd3, 2'd2, 3'd1, 8'd100, 400, "R9");
        cmp = 8'd30;
        repeat (600) @(negedge clk);
        duty(256, 31, "R9");
        run(2'd1, 2'd2, 3'd1, 8'd100, 600, "R9");
        cmp = 8'd30;
        repeat (1100) @(negedge clk);
        duty(510, 60, "R9");

        run(2'd0, 2'd1, 3'd0, 8'd5, 200, "R10");
        run(2'd0, 2'd1, 3'd2, 8'd5, 2100, "R10");
        run(2'd0, 2'd1, 3'd3, 8'd5, 3000, "R10");
        run(2'd0, 2'd1, 3'd4, 8'd5, 3000, "R10");
        run(2'd0, 2'd1, 3'd5, 8'd5, 6000, "R10");
        run(2'd0, 2'd1, 3'd6, 8'd5, 100, "R10");
        run(2'd0, 2'd1, 3'd7, 8'd5, 100, "R10");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule